// File: doc/BRIEF.md
# Pretrigger Acquisition Sequencer

The block runs one pretriggered acquisition at a time. A start trigger, either a one-cycle software strobe or a rising edge on a chosen function input line, opens the run and asks for the first scan. Each completed scan, reported by a one-cycle completion pulse, leads to a request for the next one. A single scan counter is first loaded with the minimum pretrigger scan count. While it runs down, the reference trigger is ignored. When the minimum is met, the counter is reloaded with the posttrigger count and scanning goes on without a break.

The reference trigger comes from any one of the function input lines, with a programmable edge. Every line passes through a two-flop synchronizer before its edges are detected. The first accepted reference edge starts the posttrigger phase. At the same moment the block drives a fixed-width, active-high pulse on its reference-trigger output, whatever line supplied the start. After exactly the programmed number of posttrigger scans the run stops, a done strobe is raised for one cycle, and the block waits for the next start. The output driver stays disabled from reset until software enables it.

Top module: `pretrig_sequencer`

## Requirements
- R1: During and right after reset, acqActive, scanEnable, doneFlag, refTrigData and refTrigOe are all 0.
- R2: In idle, a high swStart in a clock cycle starts a run: at that edge acqActive goes to 1 and scanEnable pulses for one cycle. swStart has no effect while a run is active.
- R3: The reference trigger is taken only from line fnLines[refSel], and only on its rising edge when refFalling is 0 or its falling edge when refFalling is 1. Edges on other lines, and edges in the other direction, are ignored.
- R4: Reference edges that arrive before preCount scans have completed since the start are ignored. With preCount of 0, the run is armed from the start.
- R5: While a run is active, every completed scan that does not end the run produces a scanEnable pulse at the edge after it. Acquisition continues without interruption across the change from the pretrigger phase to the armed phase.
- R6: After the reference edge is accepted, the run ends on the postCount-th completed scan that follows. A completion sampled in the same cycle as the acceptance does not count. With postCount of 0, the run ends at the acceptance itself.
- R7: At the end of a run, doneFlag is 1 for exactly one cycle, and acqActive falls at the same edge.
- R8: Accepting the reference edge drives refTrigData high for exactly PULSE_CYC cycles, starting at the acceptance edge.
- R9: refTrigOe is 0 from reset. It follows refOutEn with one cycle of delay.
- R10: When startLineEn is 1, a rising edge on fnLines[startSel] in idle starts a run. When startLineEn is 0, that line cannot start a run.
- R11: Only the first accepted reference edge of a run has any effect. Later edges in the posttrigger phase produce no further pulse and do not change the scan count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swStart | input | 1 | Software start strobe, one cycle |
| startLineEn | input | 1 | Allows an input line to start a run |
| startSel | input | SEL_W | Index of the start line |
| fnLines | input | NUM_LINES | Asynchronous function input lines |
| scanDone | input | 1 | One-cycle pulse, a scan has completed |
| refSel | input | SEL_W | Index of the reference-trigger line |
| refFalling | input | 1 | 1 selects the falling edge, 0 the rising edge |
| preCount | input | CNT_W | Minimum pretrigger scans |
| postCount | input | CNT_W | Posttrigger scans |
| refOutEn | input | 1 | Enables the reference-output driver |
| acqActive | output | 1 | A run is in progress |
| scanEnable | output | 1 | One-cycle request for the next scan |
| doneFlag | output | 1 | One-cycle end-of-run strobe |
| refTrigData | output | 1 | Reference-trigger output pulse |
| refTrigOe | output | 1 | Output enable for the reference-trigger pad |

## Verification
The bench sweeps every pairing of pretrigger and posttrigger counts from 0 to 3, under both edge polarities and both start sources. It varies the reference line from run to run. In each run it places a valid edge inside the pretrigger window, where a design that opened its gate too early would fire early. It also sends an edge on the wrong line and an edge in the wrong direction, either of which a faulty edge selector would accept. The zero counts are watched closely: a design that mishandled a zero posttrigger count would take an extra scan or never stop, and one that counted the completion arriving in the acceptance cycle would stop one scan short. A second reference edge during long posttrigger phases would expose a design that re-arms or re-pulses.

// File: rtl/pretrig_pkg.sv
package pretrig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_ARMED,
    ST_POST
  } seqState_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadPre;
    logic loadPost;
    logic decr;
    logic fire;
  } dpStrobe_t;

endpackage

// File: rtl/trig_front.sv
module trig_front #(
  parameter int NUM_LINES = 8,
  localparam int SEL_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lines,
  input  logic [SEL_W-1:0]     startSel,
  input  logic [SEL_W-1:0]     refSel,
  input  logic                 refFalling,
  output logic                 startEdge,
  output logic                 refEdge
);

  logic [NUM_LINES-1:0] syncA;
  logic [NUM_LINES-1:0] syncB;
  logic [NUM_LINES-1:0] histC;

  // one synchronizer plus history flop per line, so that a change of
  // selection never manufactures an edge out of two different lines
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[g] <= 1'b0;
        syncB[g] <= 1'b0;
        histC[g] <= 1'b0;
      end else begin
        syncA[g] <= lines[g];
        syncB[g] <= syncA[g];
        histC[g] <= syncB[g];
      end
    end
  end

  logic refNow, refOld;
  assign refNow = syncB[refSel];
  assign refOld = histC[refSel];

  assign refEdge   = refFalling ? (refOld & ~refNow) : (refNow & ~refOld);
  assign startEdge = syncB[startSel] & ~histC[startSel];

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import pretrig_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PULSE_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] preCount,
  input  logic [CNT_W-1:0] postCount,
  input  logic             refOutEn,
  output logic             cntZero,
  output logic             cntLast,
  output logic             pulseOut,
  output logic             pulseOe
);

  localparam int PCW = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] scanCnt;
  logic [PCW-1:0]   pulseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanCnt <= '0;
    end else if (strb.loadPre) begin
      scanCnt <= preCount;
    end else if (strb.loadPost) begin
      scanCnt <= postCount;
    end else if (strb.decr) begin
      scanCnt <= scanCnt - 1'b1;
    end
  end

  assign cntZero = (scanCnt == '0);
  assign cntLast = (scanCnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strb.fire) begin
      pulseCnt <= PCW'(PULSE_CYC);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign pulseOut = (pulseCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseOe <= 1'b0;
    else       pulseOe <= refOutEn;
  end

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.decr |-> !cntZero);

  // R8
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOut) |-> $past(strb.fire));

  // R9
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOe) |-> $past(refOutEn));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import pretrig_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      refEdge,
  input  logic      scanDone,
  input  logic      preZero,
  input  logic      cntZero,
  input  logic      cntLast,
  output dpStrobe_t strb,
  output logic      acqActive,
  output logic      scanEnable,
  output logic      doneFlag
);

  seqState_e state, nextState;
  logic scanReq, doneNext;

  always_comb begin
    nextState = state;
    strb      = '0;
    scanReq   = 1'b0;
    doneNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          scanReq = 1'b1;
          if (preZero) begin
            strb.loadPost = 1'b1;
            nextState     = ST_ARMED;
          end else begin
            strb.loadPre = 1'b1;
            nextState    = ST_PRE;
          end
        end
      end
      ST_PRE: begin
        if (scanDone) begin
          scanReq = 1'b1;
          if (cntLast) begin
            strb.loadPost = 1'b1;
            nextState     = ST_ARMED;
          end else begin
            strb.decr = 1'b1;
          end
        end
      end
      ST_ARMED: begin
        if (refEdge) begin
          strb.fire = 1'b1;
          if (cntZero) begin
            doneNext  = 1'b1;
            nextState = ST_IDLE;
          end else begin
            scanReq   = scanDone;
            nextState = ST_POST;
          end
        end else begin
          scanReq = scanDone;
        end
      end
      ST_POST: begin
        if (scanDone) begin
          if (cntLast) begin
            doneNext  = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strb.decr = 1'b1;
            scanReq   = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      scanEnable <= 1'b0;
      doneFlag   <= 1'b0;
    end else begin
      state      <= nextState;
      scanEnable <= scanReq;
      doneFlag   <= doneNext;
    end
  end

  assign acqActive = (state != ST_IDLE);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> !doneFlag);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> !acqActive);

  // R4
  pre_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRE && refEdge) |=> state != ST_POST);

  // R5
  scan_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanEnable |-> acqActive);

  // R11
  post_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POST && !scanDone) |=> state == ST_POST);

endmodule

// File: rtl/pretrig_sequencer.sv
module pretrig_sequencer
  import pretrig_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int CNT_W     = 8,
  parameter int PULSE_CYC = 4,
  localparam int SEL_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 swStart,
  input  logic                 startLineEn,
  input  logic [SEL_W-1:0]     startSel,
  input  logic [NUM_LINES-1:0] fnLines,
  input  logic                 scanDone,
  input  logic [SEL_W-1:0]     refSel,
  input  logic                 refFalling,
  input  logic [CNT_W-1:0]     preCount,
  input  logic [CNT_W-1:0]     postCount,
  input  logic                 refOutEn,
  output logic                 acqActive,
  output logic                 scanEnable,
  output logic                 doneFlag,
  output logic                 refTrigData,
  output logic                 refTrigOe
);

  logic      startEdge, refEdge, cntZero, cntLast;
  dpStrobe_t strb;

  trig_front #(.NUM_LINES(NUM_LINES)) front_i (
    .clk(clk), .rstN(rstN), .lines(fnLines), .startSel(startSel),
    .refSel(refSel), .refFalling(refFalling),
    .startEdge(startEdge), .refEdge(refEdge)
  );

  seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .startReq(swStart | (startLineEn & startEdge)),
    .refEdge(refEdge), .scanDone(scanDone),
    .preZero(preCount == '0), .cntZero(cntZero), .cntLast(cntLast),
    .strb(strb), .acqActive(acqActive), .scanEnable(scanEnable),
    .doneFlag(doneFlag)
  );

  seq_datapath #(.CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .preCount(preCount), .postCount(postCount), .refOutEn(refOutEn),
    .cntZero(cntZero), .cntLast(cntLast),
    .pulseOut(refTrigData), .pulseOe(refTrigOe)
  );

endmodule

// File: tb/pretrig_sequencer_tb.sv
module pretrig_sequencer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_LINES  = 8;
  localparam int CNT_W      = 8;
  localparam int PULSE_CYC  = 4;
  localparam int SEL_W      = $clog2(NUM_LINES);
  localparam int SCAN_DLY   = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swStart = 1'b0, startLineEn = 1'b0, scanDone = 1'b0;
  logic refFalling = 1'b0, refOutEn = 1'b0;
  logic [SEL_W-1:0] startSel = '0, refSel = '0;
  logic [NUM_LINES-1:0] fnLines = '0;
  logic [CNT_W-1:0] preCount = '0, postCount = '0;
  logic acqActive, scanEnable, doneFlag, refTrigData, refTrigOe;

  int checks = 0, fails = 0;
  int completed, postScans, refRises, pulseWidth, doneCount, postAtDone, enCount;
  bit postPhase, activeAtDone;
  bit prevActive = 0, prevRef = 0;
  int pend = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pretrig_sequencer #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .swStart(swStart), .startLineEn(startLineEn),
    .startSel(startSel), .fnLines(fnLines), .scanDone(scanDone), .refSel(refSel),
    .refFalling(refFalling), .preCount(preCount), .postCount(postCount),
    .refOutEn(refOutEn), .acqActive(acqActive), .scanEnable(scanEnable),
    .doneFlag(doneFlag), .refTrigData(refTrigData), .refTrigOe(refTrigOe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scan model and output monitor, acting only on falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (scanDone && prevActive) begin
        completed++;
        if (postPhase) postScans++;
      end
      if (refTrigData && !prevRef) refRises++;
      if (refTrigData) begin
        pulseWidth++;
        postPhase = 1;
      end
      if (doneFlag) begin
        doneCount++;
        postAtDone   = postScans;
        activeAtDone = acqActive;
      end
      if (scanEnable) begin
        enCount++;
        pend = SCAN_DLY;
      end
      scanDone = (pend == 0);
      if (pend >= 0) pend--;
      prevActive = acqActive;
      prevRef    = refTrigData;
    end
  end

  task automatic runOne(input int idx, input int pre, input int post, input bit fall);
    int rs, wl, t;
    bit useLine, base;
    rs = 1 + (idx % 7);
    wl = (rs % 7) + 1;
    useLine = idx[0];
    base = ~fall;
    @(negedge clk);
    preCount = CNT_W'(pre);
    postCount = CNT_W'(post);
    refFalling = fall;
    refSel = SEL_W'(rs);
    startSel = '0;
    startLineEn = useLine;
    fnLines = '0;
    fnLines[rs] = base;
    repeat (6) @(negedge clk);
    @(posedge clk);
    completed = 0; postScans = 0; refRises = 0; pulseWidth = 0;
    doneCount = 0; postAtDone = -1; enCount = 0; postPhase = 0; activeAtDone = 1;
    if (!useLine) begin
      @(negedge clk) fnLines[0] = 1'b1;
      repeat (6) @(negedge clk);
      chk(acqActive == 1'b0, "R10 start line disabled", int'(acqActive), 0);
      fnLines[0] = 1'b0;
      repeat (4) @(negedge clk);
      swStart = 1'b1;
      @(negedge clk) swStart = 1'b0;
      chk(acqActive == 1'b1, "R2 sw start active", int'(acqActive), 1);
      chk(scanEnable == 1'b1, "R2 first scan request", int'(scanEnable), 1);
    end else begin
      @(negedge clk) fnLines[0] = 1'b1;
      t = 0;
      while (!acqActive && t < 12) begin
        @(negedge clk);
        t++;
      end
      chk(acqActive == 1'b1, "R10 line start active", int'(acqActive), 1);
      chk(scanEnable == 1'b1, "R10 line start scan request", int'(scanEnable), 1);
      fnLines[0] = 1'b0;
    end
    if (pre >= 2) begin
      @(negedge clk) fnLines[rs] = ~base;
      repeat (3) @(negedge clk);
      fnLines[rs] = base;
      repeat (3) @(negedge clk);
    end
    // a start strobe in mid-run must be ignored (R2)
    @(negedge clk) swStart = 1'b1;
    @(negedge clk) swStart = 1'b0;
    t = 0;
    @(posedge clk);
    while (completed < pre && t < 200) begin
      @(posedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
    @(posedge clk);
    chk(refRises == 0, "R4 early edge ignored", refRises, 0);
    @(negedge clk) fnLines[wl] = ~fnLines[wl];
    repeat (4) @(negedge clk);
    fnLines[wl] = ~fnLines[wl];
    repeat (4) @(negedge clk);
    @(posedge clk);
    chk(refRises == 0, "R3 other line ignored", refRises, 0);
    @(negedge clk) fnLines[rs] = ~base;
    repeat (5) @(negedge clk);
    @(posedge clk);
    chk(refRises == 0, "R3 wrong direction ignored", refRises, 0);
    chk(acqActive == 1'b1, "R5 armed run continues", int'(acqActive), 1);
    @(negedge clk) fnLines[rs] = base;
    t = 0;
    while (refRises == 0 && t < 12) begin
      @(posedge clk);
      t++;
    end
    chk(refRises == 1, "R8 pulse on accepted edge", refRises, 1);
    if (post >= 3) begin
      @(negedge clk) fnLines[rs] = ~base;
      repeat (3) @(negedge clk);
      fnLines[rs] = base;
    end
    t = 0;
    while (doneCount == 0 && t < 300) begin
      @(posedge clk);
      t++;
    end
    repeat (PULSE_CYC + 4) @(posedge clk);
    chk(doneCount == 1, "R7 one done strobe", doneCount, 1);
    chk(activeAtDone == 1'b0, "R7 active low with done", int'(activeAtDone), 0);
    chk(acqActive == 1'b0, "R7 idle after run", int'(acqActive), 0);
    chk(postAtDone == post, "R6 posttrigger scan count", postAtDone, post);
    chk(refRises == 1, "R11 single pulse per run", refRises, 1);
    chk(pulseWidth == PULSE_CYC, "R8 pulse width", pulseWidth, PULSE_CYC);
    chk((completed - postScans) >= pre, "R4 pretrigger minimum", completed - postScans, pre);
    if (post > 0)
      chk(enCount == completed, "R5 request per completed scan", enCount, completed);
    while (pend >= 0) @(posedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(acqActive == 1'b0, "R1 acqActive in reset", int'(acqActive), 0);
    chk(scanEnable == 1'b0 && doneFlag == 1'b0, "R1 strobes in reset",
        int'(scanEnable) + int'(doneFlag), 0);
    chk(refTrigData == 1'b0, "R1 pulse in reset", int'(refTrigData), 0);
    chk(refTrigOe == 1'b0, "R9 driver off in reset", int'(refTrigOe), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(acqActive == 1'b0 && scanEnable == 1'b0, "R1 idle after reset",
        int'(acqActive) + int'(scanEnable), 0);
    chk(refTrigOe == 1'b0, "R9 driver off until enabled", int'(refTrigOe), 0);
    refOutEn = 1'b1;
    @(negedge clk);
    chk(refTrigOe == 1'b1, "R9 driver enabled", int'(refTrigOe), 1);
    for (int p = 0; p < 4; p++)
      for (int q = 0; q < 4; q++)
        for (int f = 0; f < 2; f++)
          runOne(p * 8 + q * 2 + f, p, q, f[0]);
    @(negedge clk) refOutEn = 1'b0;
    @(negedge clk);
    chk(refTrigOe == 1'b0, "R9 driver disabled again", int'(refTrigOe), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule